// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Port

This block moves characters between a byte-wide host bus and a pair of serial lines. The transmitter and the receiver run at the same time and do not depend on each other. The host writes a character into a transmit holding register. The block wraps the character in a start bit, an optional parity bit and one or two stop bits, then shifts it out least significant bit first. The receiver watches the incoming line and rebuilds each character. It checks the framing and the parity, then places the character in a receive buffer with error flags that the host reads when the character arrives.

A rate register sets the bit time for both directions. The rate engine produces a tick every `rate+1` clock cycles, and one bit lasts 16 ticks. The slowest setting, rate `0xFF`, switches the transmitter to two stop bits by itself. Three handshake outputs are plain control-register bits. Three handshake inputs are read through a line-state port of their own. The serial engines have no handshake status inside them, so there is nothing to force.

Top module: `serial_port_core`

## Requirements
- R1: After reset the status register (address 1) reads 0x10, the control register (address 2) and the rate register (address 3) read 0x00, `txd` is high and the three handshake outputs are low.
- R2: A transmitted frame is one low start bit, then 8 data bits least significant first, then the parity bit if one is enabled, then one high stop bit. Every bit lasts 16×(rate+1) clocks, so consecutive frames with no parity start exactly 10×16×(rate+1) clocks apart.
- R3: When the rate register holds 0xFF the transmitter sends two stop bits, so back-to-back frames start 11×16×256 clocks apart.
- R4: Control bits [2:0] select the parity:
  - 0: none.
  - 1: odd (the data bits and the parity bit hold an odd number of ones).
  - 2: even.
  - 3: the parity bit is always 1.
  - 4: the parity bit is always 0.
  - 5 to 7: none.
- R5: The receiver passes the line through a two-stage synchronizer. It takes a low level as a start bit only if the line is still low half a bit later, then samples each following bit at its centre. A completed character appears at address 0 and sets status bit 3 (receive full).
- R6: Status bit 0 is set when the received parity bit differs from the one the selected mode calls for.
- R7: Status bit 1 is set when the first stop bit is sampled low.
- R8: If a character completes while status bit 3 is still set, status bit 2 (overrun) is set, the new character is discarded and the buffered one is kept.
- R9: Reading address 0 clears status bits 3, 2, 1 and 0. Writes to addresses 1 and 4 have no effect.
- R10: Status bit 4 is high while the transmit holding register is empty. The transmitter takes a held character only on a tick when it is idle or finishing a frame. A write while the holding register is full replaces the held character, so only the last one written is sent.
- R11: Control bits [3], [4] and [5] drive `term_ready`, `req_send` and `aux_out`, and the control register reads back as written in bits [5:0]. Address 4 reads {5'b0, `aux_in`, `clear_send_in`, `data_mode_in`}.
- R12: Transmit and receive run at the same time: a frame looped from `txd` to `rxd` is received correctly while the transmitter keeps sending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe (used for read side effects) |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line, asynchronous |
| term_ready | output | 1 | Terminal-ready handshake output |
| req_send | output | 1 | Request-to-send handshake output |
| aux_out | output | 1 | Optional handshake output |
| data_mode_in | input | 1 | Data-mode handshake input |
| clear_send_in | input | 1 | Clear-to-send handshake input |
| aux_in | input | 1 | Optional handshake input |

## Verification
A wrong sub-bit count or a wrong bit index in the transmitter shows on `txd` within one bit time. It appears as a misplaced edge or a wrong sampled bit, and the bench decodes the line independently at bit centres and measures start-to-start distances in clocks. A receiver that slips its sampling phase or loses its error state shows up at the first status read after the stop bit, as a wrong character or a wrong flag. The handshake outputs are compared with a model of the control register on every clock, so a corrupted control bit shows up one cycle after the write.

// File: rtl/sp_pkg.sv
package sp_pkg;

   localparam int BUS_AW = 3;
   localparam int BUS_DW = 8;

   localparam logic [BUS_AW-1:0] ADDR_DATA   = 3'd0;
   localparam logic [BUS_AW-1:0] ADDR_STATUS = 3'd1;
   localparam logic [BUS_AW-1:0] ADDR_CTRL   = 3'd2;
   localparam logic [BUS_AW-1:0] ADDR_RATE   = 3'd3;
   localparam logic [BUS_AW-1:0] ADDR_LINE   = 3'd4;

   typedef enum logic [2:0] {
      PAR_NONE  = 3'd0,
      PAR_ODD   = 3'd1,
      PAR_EVEN  = 3'd2,
      PAR_ONE   = 3'd3,
      PAR_ZERO  = 3'd4
   } par_mode_e;

   // returns {enabled, parity bit} for a data byte under a mode code
   function automatic logic [1:0] parity_of(input logic [2:0] mode, input logic [7:0] d);
      logic [1:0] r;
      case (mode)
         PAR_ODD:  r = {1'b1, ~(^d)};
         PAR_EVEN: r = {1'b1, ^d};
         PAR_ONE:  r = 2'b11;
         PAR_ZERO: r = 2'b10;
         default:  r = 2'b00;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/sp_rate_gen.sv
module sp_rate_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = (cnt >= div);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sp_tx.sv
module sp_tx #(
   parameter int DATA_BITS = 8,
   parameter int OSR       = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 hold_full,
   input  logic [DATA_BITS-1:0] hold_data,
   input  logic [2:0]           par_mode,
   input  logic                 two_stop,
   output logic                 load,
   output logic                 busy,
   output logic                 txd
);
   localparam int FRAME_W = DATA_BITS + 4;
   localparam int CNT_W   = $clog2(OSR);
   localparam int LEN_W   = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] shreg, frame;
   logic [LEN_W-1:0]   left, len;
   logic [CNT_W-1:0]   sub;
   logic [1:0]         pb;
   logic               last_slot;

   always_comb begin
      pb    = sp_pkg::parity_of(par_mode, 8'(hold_data));
      frame = '1;
      frame[0] = 1'b0;
      frame[DATA_BITS:1] = hold_data;
      if (pb[1]) frame[DATA_BITS+1] = pb[0];
      len = LEN_W'(1 + DATA_BITS + 1) + LEN_W'(pb[1]) + LEN_W'(two_stop);
   end

   assign last_slot = (sub == CNT_W'(OSR-1)) && (left == LEN_W'(1));
   assign load      = tick && hold_full && (!busy || last_slot);
   assign txd       = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '1;
         left  <= '0;
         sub   <= '0;
         busy  <= 1'b0;
      end else if (load) begin
         shreg <= frame;
         left  <= len;
         sub   <= '0;
         busy  <= 1'b1;
      end else if (tick && busy) begin
         if (sub == CNT_W'(OSR-1)) begin
            sub   <= '0;
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - 1'b1;
            if (left == LEN_W'(1)) busy <= 1'b0;
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sp_rx.sv
module sp_rx #(
   parameter int DATA_BITS   = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 rxd,
   input  logic [2:0]           par_mode,
   output logic                 done,
   output logic [DATA_BITS-1:0] data,
   output logic                 par_err,
   output logic                 frm_err
);
   localparam int CNT_W = $clog2(OSR);
   localparam int IDX_W = $clog2(DATA_BITS);

   typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_e;

   rx_state_e            st;
   logic [CNT_W-1:0]     sub;
   logic [IDX_W-1:0]     idx;
   logic [DATA_BITS-1:0] sh;
   logic                 par_smp;
   logic                 rx_s;
   logic [1:0]           pexp;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         logic s0;
         always_ff @(posedge clk) begin
            if (!rst_n) s0 <= 1'b1;
            else        s0 <= rxd;
         end
         assign rx_s = s0;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], rxd};
         end
         assign rx_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   assign pexp = sp_pkg::parity_of(par_mode, 8'(sh));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         sub     <= '0;
         idx     <= '0;
         sh      <= '0;
         par_smp <= 1'b0;
         done    <= 1'b0;
         data    <= '0;
         par_err <= 1'b0;
         frm_err <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (st)
               S_IDLE: if (!rx_s) begin
                  st  <= S_START;
                  sub <= '0;
               end
               S_START: begin
                  if (sub == CNT_W'(OSR/2 - 1)) begin
                     sub <= '0;
                     idx <= '0;
                     st  <= rx_s ? S_IDLE : S_DATA;
                  end else sub <= sub + 1'b1;
               end
               S_DATA: begin
                  if (sub == CNT_W'(OSR-1)) begin
                     sub <= '0;
                     sh  <= {rx_s, sh[DATA_BITS-1:1]};
                     idx <= idx + 1'b1;
                     if (idx == IDX_W'(DATA_BITS-1))
                        st <= pexp[1] ? S_PAR : S_STOP;
                  end else sub <= sub + 1'b1;
               end
               S_PAR: begin
                  if (sub == CNT_W'(OSR-1)) begin
                     sub     <= '0;
                     par_smp <= rx_s;
                     st      <= S_STOP;
                  end else sub <= sub + 1'b1;
               end
               S_STOP: begin
                  if (sub == CNT_W'(OSR-1)) begin
                     sub     <= '0;
                     done    <= 1'b1;
                     data    <= sh;
                     frm_err <= !rx_s;
                     par_err <= pexp[1] && (par_smp != pexp[0]);
                     st      <= S_IDLE;
                  end else sub <= sub + 1'b1;
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/serial_port_core.sv
module serial_port_core #(
   parameter int DATA_BITS   = 8,
   parameter int OSR         = 16,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [sp_pkg::BUS_AW-1:0] bus_addr,
   input  logic                      bus_wr,
   input  logic [sp_pkg::BUS_DW-1:0] bus_wdata,
   input  logic                      bus_rd,
   output logic [sp_pkg::BUS_DW-1:0] bus_rdata,
   output logic                      txd,
   input  logic                      rxd,
   output logic                      term_ready,
   output logic                      req_send,
   output logic                      aux_out,
   input  logic                      data_mode_in,
   input  logic                      clear_send_in,
   input  logic                      aux_in
);
   import sp_pkg::*;

   initial begin
      assert (DATA_BITS >= 5 && DATA_BITS <= BUS_DW) else $error("DATA_BITS out of range");
      assert (OSR >= 4 && (OSR & (OSR-1)) == 0) else $error("OSR must be a power of two >= 4");
      assert (DIV_W >= 1 && DIV_W <= BUS_DW) else $error("DIV_W out of range");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be >= 1");
   end

   logic [5:0]           ctrl;
   logic [DIV_W-1:0]     rate;
   logic [DATA_BITS-1:0] hold_data;
   logic                 hold_full;
   logic [DATA_BITS-1:0] rx_buf;
   logic                 rx_full, pe, fe, ovr;
   logic                 tick, tx_load, tx_busy;
   logic                 rx_done, rx_pe, rx_fe;
   logic [DATA_BITS-1:0] rx_data;
   logic                 wr_data_sel, rd_data_sel, two_stop;

   assign wr_data_sel = bus_wr && (bus_addr == ADDR_DATA);
   assign rd_data_sel = bus_rd && (bus_addr == ADDR_DATA);
   assign two_stop    = (rate == '1);

   assign term_ready = ctrl[3];
   assign req_send   = ctrl[4];
   assign aux_out    = ctrl[5];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
         rate <= '0;
      end else if (bus_wr) begin
         if (bus_addr == ADDR_CTRL) ctrl <= bus_wdata[5:0];
         if (bus_addr == ADDR_RATE) rate <= bus_wdata[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_data <= '0;
         hold_full <= 1'b0;
      end else if (wr_data_sel) begin
         hold_data <= bus_wdata[DATA_BITS-1:0];
         hold_full <= 1'b1;
      end else if (tx_load) begin
         hold_full <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_buf  <= '0;
         rx_full <= 1'b0;
         pe      <= 1'b0;
         fe      <= 1'b0;
         ovr     <= 1'b0;
      end else begin
         if (rd_data_sel) begin
            rx_full <= 1'b0;
            pe      <= 1'b0;
            fe      <= 1'b0;
            ovr     <= 1'b0;
         end
         if (rx_done) begin
            if (rx_full && !rd_data_sel) begin
               ovr <= 1'b1;
            end else begin
               rx_buf  <= rx_data;
               rx_full <= 1'b1;
               pe      <= rx_pe;
               fe      <= rx_fe;
            end
         end
      end
   end

   always_comb begin
      case (bus_addr)
         ADDR_DATA:   bus_rdata = BUS_DW'(rx_buf);
         ADDR_STATUS: bus_rdata = {3'b000, !hold_full, rx_full, ovr, fe, pe};
         ADDR_CTRL:   bus_rdata = {2'b00, ctrl};
         ADDR_RATE:   bus_rdata = BUS_DW'(rate);
         ADDR_LINE:   bus_rdata = {5'b00000, aux_in, clear_send_in, data_mode_in};
         default:     bus_rdata = '0;
      endcase
   end

   sp_rate_gen #(.DIV_W(DIV_W)) u_rate (
      .clk(clk), .rst_n(rst_n), .div(rate), .tick(tick)
   );

   sp_tx #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .hold_full(hold_full), .hold_data(hold_data),
      .par_mode(ctrl[2:0]), .two_stop(two_stop),
      .load(tx_load), .busy(tx_busy), .txd(txd)
   );

   sp_rx #(.DATA_BITS(DATA_BITS), .OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
      .par_mode(ctrl[2:0]), .done(rx_done), .data(rx_data),
      .par_err(rx_pe), .frm_err(rx_fe)
   );
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
   parameter int DATA_BITS = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      tick,
   input logic                      txd,
   input logic                      tx_load,
   input logic                      hold_full,
   input logic                      wr_data_sel,
   input logic                      rd_data_sel,
   input logic                      rx_done,
   input logic                      rx_full,
   input logic                      pe,
   input logic                      fe,
   input logic                      ovr,
   input logic [DATA_BITS-1:0]      rx_buf
);
   AST_TXD_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(txd)); // R2

   AST_WRITE_FILLS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data_sel |=> hold_full); // R10

   AST_LOAD_FREES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load && !wr_data_sel |=> !hold_full); // R10

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_sel && !rx_done |=> !rx_full && !pe && !fe && !ovr); // R9

   AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && rx_full && !rd_data_sel |=> ovr && $stable(rx_buf)); // R8

   AST_FLAGS_NEED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (pe || fe || ovr) |-> rx_full); // R6
endmodule

bind serial_port_core sp_checker #(.DATA_BITS(DATA_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .txd(txd), .tx_load(tx_load),
   .hold_full(hold_full), .wr_data_sel(wr_data_sel), .rd_data_sel(rd_data_sel),
   .rx_done(rx_done), .rx_full(rx_full), .pe(pe), .fe(fe), .ovr(ovr), .rx_buf(rx_buf)
);

// File: tb/sim_serial_port_core.sv
`timescale 1ns/1ps
module sim_serial_port_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       txd, rxd;
   logic       loop = 1'b1, bench_rx = 1'b1;
   logic       tr, rs, ax_o;
   logic       dm = 1'b0, cts = 1'b0, ax_i = 1'b0;
   logic [5:0] mctrl = '0;
   int         checks = 0, errors = 0;
   longint     cyc = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   assign rxd = loop ? txd : bench_rx;

   serial_port_core u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
      .bus_rd(rd), .bus_rdata(rdata), .txd(txd), .rxd(rxd),
      .term_ready(tr), .req_send(rs), .aux_out(ax_o),
      .data_mode_in(dm), .clear_send_in(cts), .aux_in(ax_i)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // every-clock comparison of handshake outputs against the control model (R11)
   always @(posedge clk) begin
      #1;
      if (rst_n) chk({ax_o, rs, tr} == mctrl[5:3], "R11 handshake outputs", {ax_o, rs, tr}, mctrl[5:3]);
   end

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(posedge clk); if (a == 3'd2) mctrl = d[5:0];
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
      logic [7:0] v;
      bus_read(a, v);
      chk(v == e, req, v, e);
   endtask

   // expected frame: returns bits (LSB sent first) and length
   task automatic make_frame(input logic [7:0] d, input int mode, input bit two,
                             output logic [15:0] f, output int n);
      f = '1; f[0] = 1'b0; f[8:1] = d; n = 9;
      case (mode)
         1: begin f[9] = ~(^d); n = 10; end
         2: begin f[9] = ^d;    n = 10; end
         3: begin f[9] = 1'b1;  n = 10; end
         4: begin f[9] = 1'b0;  n = 10; end
         default: ;
      endcase
      n = n + (two ? 2 : 1);
   endtask

   task automatic decode_tx(input int n, input int p, output logic [15:0] bits, output longint t0);
      bits = '1;
      do @(negedge clk); while (txd !== 1'b0);
      t0 = cyc;
      repeat (p/2) @(negedge clk);
      bits[0] = txd;
      for (int i = 1; i < n; i++) begin
         repeat (p) @(negedge clk);
         bits[i] = txd;
      end
   endtask

   task automatic drive_rx(input logic [15:0] f, input int n, input int p);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); bench_rx = f[i];
         repeat (p-1) @(negedge clk);
      end
      @(negedge clk); bench_rx = 1'b1;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] ef, gf, ef2, gf2;
      int          n, n2;
      longint      t1, t2;
      logic [7:0]  v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      expect_reg(3'd1, 8'h10, "R1 status after reset");
      expect_reg(3'd2, 8'h00, "R1 control after reset");
      expect_reg(3'd3, 8'h00, "R1 rate after reset");
      chk(txd === 1'b1, "R1 txd idle", txd, 1);

      // R11 handshake inputs via line port, writes to status/line ignored (R9)
      dm = 1; cts = 0; ax_i = 1;
      expect_reg(3'd4, 8'h05, "R11 line port");
      dm = 0; cts = 1; ax_i = 0;
      expect_reg(3'd4, 8'h02, "R11 line port");
      bus_write(3'd1, 8'hFF);
      bus_write(3'd4, 8'hFF);
      expect_reg(3'd1, 8'h10, "R9 status write ignored");
      expect_reg(3'd4, 8'h02, "R9 line write ignored");

      // R2 R5 R12 basic loopback at rate 3 (bit = 64 clocks)
      bus_write(3'd3, 8'd3);
      expect_reg(3'd3, 8'd3, "R11 rate readback");
      bus_write(3'd2, 8'h18);
      expect_reg(3'd2, 8'h18, "R11 control readback");
      make_frame(8'hA5, 0, 0, ef, n);
      fork
         decode_tx(n, 64, gf, t1);
         bus_write(3'd0, 8'hA5);
      join
      chk(gf == ef, "R2 frame bits", gf, ef);
      repeat (64) @(negedge clk);
      expect_reg(3'd1, 8'h18, "R5 status after receive");
      expect_reg(3'd0, 8'hA5, "R12 loopback data");
      expect_reg(3'd1, 8'h10, "R9 read clears full");

      // R4 R6 parity modes 1..5
      for (int m = 1; m <= 5; m++) begin
         logic [7:0] d;
         d = 8'h31 + 8'(m * 7);
         bus_write(3'd2, 8'(m) | ((m % 2 == 1) ? 8'h08 : 8'h30));
         make_frame(d, m, 0, ef, n);
         fork
            decode_tx(n, 64, gf, t1);
            bus_write(3'd0, d);
         join
         chk(gf == ef, "R4 parity frame", gf, ef);
         repeat (64) @(negedge clk);
         expect_reg(3'd1, 8'h18, "R6 no parity error");
         expect_reg(3'd0, d, "R4 received data");
      end

      // R10 overwrite of holding register; R2 spacing; R8 overrun
      bus_write(3'd2, 8'h00);
      make_frame(8'h11, 0, 0, ef, n);
      make_frame(8'h33, 0, 0, ef2, n2);
      fork
         begin
            decode_tx(n, 64, gf, t1);
            decode_tx(n2, 64, gf2, t2);
         end
         begin
            bus_write(3'd0, 8'h11);
            repeat (8) @(negedge clk);
            bus_write(3'd0, 8'h22);
            expect_reg(3'd1, 8'h00, "R10 holding full");
            bus_write(3'd0, 8'h33);
         end
      join
      chk(gf == ef, "R10 first frame", gf, ef);
      chk(gf2 == ef2, "R10 overwritten frame", gf2, ef2);
      chk(t2 - t1 == 640, "R2 start spacing", t2 - t1, 640);
      begin
         int lows = 0;
         repeat (1400) begin @(negedge clk); if (txd == 1'b0) lows++; end
         chk(lows == 0, "R10 no third frame", lows, 0);
      end
      expect_reg(3'd1, 8'h1C, "R8 overrun flag");
      expect_reg(3'd0, 8'h11, "R8 old data kept");
      expect_reg(3'd1, 8'h10, "R9 read clears overrun");

      // R6 parity error injected
      loop = 1'b0;
      bus_write(3'd2, 8'h02);
      make_frame(8'h5A, 2, 0, ef, n);
      ef[9] = ~ef[9];
      drive_rx(ef, n, 64);
      repeat (64) @(negedge clk);
      expect_reg(3'd1, 8'h19, "R6 parity error");
      expect_reg(3'd0, 8'h5A, "R6 data with parity error");
      expect_reg(3'd1, 8'h10, "R9 read clears parity error");

      // R7 framing error
      bus_write(3'd2, 8'h00);
      make_frame(8'hC3, 0, 0, ef, n);
      ef[9] = 1'b0;
      drive_rx(ef, n, 64);
      repeat (200) @(negedge clk);
      expect_reg(3'd1, 8'h1A, "R7 framing error");
      expect_reg(3'd0, 8'hC3, "R7 data with framing error");
      expect_reg(3'd1, 8'h10, "R9 read clears framing error");

      // R3 slowest rate: two stop bits
      loop = 1'b1;
      bus_write(3'd3, 8'hFF);
      make_frame(8'h81, 0, 1, ef, n);
      make_frame(8'h7E, 0, 1, ef2, n2);
      fork
         begin
            decode_tx(n, 4096, gf, t1);
            decode_tx(n2, 4096, gf2, t2);
         end
         begin
            bus_write(3'd0, 8'h81);
            repeat (300) @(negedge clk);
            bus_write(3'd0, 8'h7E);
         end
      join
      chk(gf == ef, "R3 slow frame one", gf, ef);
      chk(gf2 == ef2, "R3 slow frame two", gf2, ef2);
      chk(t2 - t1 == 11 * 4096, "R3 two-stop spacing", t2 - t1, 11 * 4096);
      expect_reg(3'd1, 8'h1C, "R8 overrun at slow rate");
      expect_reg(3'd0, 8'h81, "R3 slow data received");

      finish_run();
   end
endmodule